// File: doc/BRIEF.md
# Console Serial Receiver with Register Port

This block takes an asynchronous serial line from a console and turns it into 16-bit register reads for a host processor. Software sets the character format through a control register: 5 to 8 data bits, an optional even parity bit, and one, one-and-a-half or two stop bits. The same register holds the interrupt enable. The host then reads an input status word and the received character. When a valid character arrives, a data-available flag is set, and an interrupt follows if it is enabled.

A maintenance-monitor input marks the periods when a built-in operator monitor owns the console. While that input is high:
- the data-available status and its interrupt are hidden;
- characters that arrive do not set the flag, although the character holding register still takes them;
- a data read leaves the flag untouched.

Each line bit is sampled at its centre. Sampling uses a 16x oversampling clock taken from a parameterised divider of the system clock.

The register port is a plain strobe interface. A read is a cycle with `reg_en` high and `reg_wr` low; `rdata` is valid combinationally in that same cycle, and any side effect of the read takes place at the closing clock edge. A write is a cycle with `reg_en` and `reg_wr` both high. The port never stalls, so there is no back-pressure. The serial input has no handshake either: a character that is not read before the next one arrives is overwritten.

Top module: `con_rx_port`

## Requirements
- R1: After reset, the status read, the data read and `irq` are all zero.
- R2: Control bits 12:11 select the data length: 00 gives 8 bits, 01 gives 7, 10 gives 6 and 11 gives 5. Data bits arrive LSB first. The character is right-justified in the data word, with all higher bits zero.
- R3: Control bit 13 at 1 selects one stop bit. At 0 it selects two stop bits, or one and a half when the length is 5. A stop bit sampled low discards the character, and the flag is not set.
- R4: Control bit 14 at 1 adds an even parity bit after the data bits. A parity mismatch discards the character.
- R5: Control bit 0 enables the interrupt. It reads back on status bit 0. `irq` is high exactly when the enable is set, a character is available and the monitor input is low.
- R6: Status bit 3 reports data available and reads 0 while `mon_active` is high. A character received while `mon_active` is high does not set the flag, but it does replace the held character.
- R7: A data read (select 0) returns the last character received. It clears data available only when `mon_active` is low; with the monitor active, the flag is kept.
- R8: Select 1 is a no-operation: it reads 0 and changes nothing. Writes to any select other than 3 are ignored.
- R9: Each bit is sampled at its midpoint, counted on a 16x oversampling tick that comes from the clock divided by `CLK_DIV`. On an idle line, a low pulse shorter than half a bit is not taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 1 | Serial line, idle high |
| mon_active | input | 1 | Maintenance monitor owns the console |
| reg_en | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 2 | 0 data, 1 no-op, 2 status, 3 control |
| wdata | input | WORD_W | Write data |
| rdata | output | WORD_W | Read data, combinational, 0 when not reading |
| irq | output | 1 | Data-available interrupt |

## Verification
The hardest state to reach is a pending character whose flag is hidden by the monitor input, and then read while the monitor is still active. In that state the flag must survive the read and reappear when the monitor drops. The bench builds it in order: it receives a character, raises `mon_active`, reads the data, lowers the input, and checks status and `irq` at each step. It also sends a character wholly inside a monitor window, to show that the holding register moves while the flag does not. Format coverage comes from a sweep of all sixteen length, stop and parity settings with computed characters.

// File: rtl/con_rx_pkg.sv
package con_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP1,
    ST_STOP2,
    ST_RECOV
  } rx_state_t;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_NOP  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_t;

  typedef struct packed {
    logic       par_en;
    logic       one_stop;
    logic [1:0] len_sel;
    logic       irq_en;
  } rx_cfg_t;

  localparam int CTL_IE_BIT    = 0;
  localparam int CTL_LEN_LO    = 11;
  localparam int CTL_STOP_BIT  = 13;
  localparam int CTL_PAR_BIT   = 14;
  localparam int STAT_IE_BIT   = 0;
  localparam int STAT_AVL_BIT  = 3;

endpackage

// File: rtl/con_rx_baud.sv
module con_rx_baud #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);

  generate
    if (CLK_DIV > 1) begin : g_gap
      // R9: oversampling ticks are spaced by the divider
      a_r9_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/con_rx_frame.sv
module con_rx_frame
  import con_rx_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int MAXB = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rxd,
  input  rx_cfg_t         cfg,
  output logic            char_vld,
  output logic [MAXB-1:0] char_data
);
  localparam int TW   = $clog2(OVS);
  localparam int BW   = $clog2(MAXB);
  localparam int HALF = OVS / 2;
  localparam logic [TW-1:0] T_FULL  = TW'(OVS - 1);
  localparam logic [TW-1:0] T_HALF  = TW'(HALF - 1);
  localparam logic [TW-1:0] T_SHORT = TW'(OVS - OVS / 4 - 1);

  logic [1:0]      sync;
  logic            rx_s;
  rx_state_t       st;
  logic [TW-1:0]   tcnt;
  logic [BW-1:0]   bidx;
  logic [MAXB-1:0] shreg;
  logic            par_acc;
  logic            perr;
  rx_cfg_t         cfg_q;
  logic [BW:0]     nbits;
  logic            last_bit;
  logic            mid;
  logic            half_stop;
  logic [TW-1:0]   stop2_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else sync <= {sync[0], rxd};
  end
  assign rx_s = sync[1];

  assign nbits     = (BW+1)'(MAXB) - (BW+1)'(cfg_q.len_sel);
  assign last_bit  = ({1'b0, bidx} == (nbits - 1'b1));
  assign mid       = tick && (tcnt == T_FULL);
  assign half_stop = (cfg_q.len_sel == 2'b11);
  assign stop2_lim = half_stop ? T_SHORT : T_FULL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      par_acc   <= 1'b0;
      perr      <= 1'b0;
      cfg_q     <= '0;
      char_vld  <= 1'b0;
      char_data <= '0;
    end else begin
      char_vld <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          tcnt <= '0;
          if (tick && !rx_s) st <= ST_START;
        end
        ST_START: begin
          if (tick) begin
            if (tcnt == T_HALF) begin
              tcnt <= '0;
              if (!rx_s) begin
                st      <= ST_DATA;
                bidx    <= '0;
                par_acc <= 1'b0;
                perr    <= 1'b0;
                cfg_q   <= cfg;
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (mid) begin
            tcnt    <= '0;
            shreg   <= {rx_s, shreg[MAXB-1:1]};
            par_acc <= par_acc ^ rx_s;
            bidx    <= bidx + 1'b1;
            if (last_bit) st <= cfg_q.par_en ? ST_PAR : ST_STOP1;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (mid) begin
            tcnt <= '0;
            perr <= par_acc ^ rx_s;
            st   <= ST_STOP1;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_STOP1: begin
          if (mid) begin
            tcnt <= '0;
            if (!rx_s) begin
              st <= ST_RECOV;
            end else if (cfg_q.one_stop) begin
              st        <= ST_IDLE;
              char_vld  <= !perr;
              char_data <= shreg >> cfg_q.len_sel;
            end else begin
              st <= ST_STOP2;
            end
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_STOP2: begin
          if (tick && tcnt == stop2_lim) begin
            tcnt <= '0;
            if (!rx_s) begin
              st <= ST_RECOV;
            end else begin
              st        <= ST_IDLE;
              char_vld  <= !perr;
              char_data <= shreg >> cfg_q.len_sel;
            end
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_RECOV: begin
          tcnt <= '0;
          if (rx_s) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: a character is only delivered after a high stop sample
  a_r3_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |-> $past(rx_s));

  // R9: data phase is entered only when the start midpoint sample was low
  a_r9_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && $past(st) == ST_START) |-> !$past(rx_s));

  // R2: delivered character has nothing above the configured length
  a_r2_right_just: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |=> ((char_data >> nbits) == '0));

endmodule

// File: rtl/con_rx_regs.sv
module con_rx_regs
  import con_rx_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int MAXB   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] wdata,
  input  logic              mon_active,
  input  logic              char_vld,
  input  logic [MAXB-1:0]   char_data,
  output rx_cfg_t           cfg,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  reg_sel_t        sel;
  logic            rd_stb;
  logic            wr_ctl;
  logic            data_rd;
  logic [MAXB-1:0] hold;
  logic            avail;
  logic            avail_vis;

  assign sel     = reg_sel_t'(reg_sel);
  assign rd_stb  = reg_en && !reg_wr;
  assign wr_ctl  = reg_en && reg_wr && (sel == SEL_CTRL);
  assign data_rd = rd_stb && (sel == SEL_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_ctl) begin
      cfg.irq_en   <= wdata[CTL_IE_BIT];
      cfg.len_sel  <= wdata[CTL_LEN_LO+1:CTL_LEN_LO];
      cfg.one_stop <= wdata[CTL_STOP_BIT];
      cfg.par_en   <= wdata[CTL_PAR_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hold <= '0;
    else if (char_vld) hold <= char_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) avail <= 1'b0;
    else if (char_vld && !mon_active) avail <= 1'b1;
    else if (data_rd && !mon_active) avail <= 1'b0;
  end

  assign avail_vis = avail && !mon_active;
  assign irq       = cfg.irq_en && avail_vis;

  always_comb begin
    rdata = '0;
    if (rd_stb) begin
      unique case (sel)
        SEL_DATA: rdata = WORD_W'(hold);
        SEL_STAT: begin
          rdata[STAT_IE_BIT]  = cfg.irq_en;
          rdata[STAT_AVL_BIT] = avail_vis;
        end
        default: rdata = '0;
      endcase
    end
  end

  // R7: a data read with the monitor idle clears the flag
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !mon_active && !char_vld) |=> !avail);

  // R7: a data read with the monitor active keeps the flag
  a_r7_mon_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && mon_active) |=> (avail == $past(avail)));

  // R6: the flag cannot be raised while the monitor owns the console
  a_r6_mon_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!avail && mon_active) |=> !avail);

  // R6: a good character with the monitor idle raises the flag
  a_r6_char_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld && !mon_active) |=> avail);

  // R8: the no-operation select leaves all state alone
  a_r8_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && sel == SEL_NOP && !char_vld) |=> ($stable(avail) && $stable(cfg)));

endmodule

// File: rtl/con_rx_port.sv
module con_rx_port
  import con_rx_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int OVS     = 16,
  parameter int MAXB    = 8,
  parameter int WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              mon_active,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  logic            tick;
  rx_cfg_t         cfg;
  logic            char_vld;
  logic [MAXB-1:0] char_data;

  con_rx_baud #(.CLK_DIV(CLK_DIV)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  con_rx_frame #(.OVS(OVS), .MAXB(MAXB)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .rxd      (rxd),
    .cfg      (cfg),
    .char_vld (char_vld),
    .char_data(char_data)
  );

  con_rx_regs #(.WORD_W(WORD_W), .MAXB(MAXB)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_en    (reg_en),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .wdata     (wdata),
    .mon_active(mon_active),
    .char_vld  (char_vld),
    .char_data (char_data),
    .cfg       (cfg),
    .rdata     (rdata),
    .irq       (irq)
  );

  // R5: interrupt never shows while the monitor is active
  a_r5_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_active && $past(mon_active)) |-> !irq);

endmodule

// File: tb/con_rx_port_bench.sv
module con_rx_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_DIV    = 4;
  localparam int BITC       = 16 * CLK_DIV;
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rxd = 1'b1;
  logic        mon_active = 1'b0;
  logic        reg_en = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  con_rx_port #(.CLK_DIV(CLK_DIV)) u_con_rx_port (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .mon_active(mon_active),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_sel(reg_sel), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b0; reg_sel = s;
    #1 v = rdata;
    @(negedge clk);
    reg_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    reg_en = 1'b1; reg_wr = 1'b1; reg_sel = s; wdata = v;
    @(negedge clk);
    reg_en = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic hold_line(input logic v, input int clocks);
    rxd = v;
    repeat (clocks) @(negedge clk);
  endtask

  // half_stops: stop length in half bits (2, 3 or 4)
  task automatic send(input logic [7:0] v, input int nb, input bit par,
                      input int half_stops, input bit bad_par, input bit bad_stop);
    logic p;
    p = 1'b0;
    @(negedge clk);
    hold_line(1'b0, BITC);
    for (int i = 0; i < nb; i++) begin
      hold_line(v[i], BITC);
      p = p ^ v[i];
    end
    if (par) hold_line(p ^ bad_par, BITC);
    if (bad_stop) begin
      hold_line(1'b0, BITC);
      hold_line(1'b1, (half_stops - 2) * BITC / 2);
    end else begin
      hold_line(1'b1, half_stops * BITC / 2);
    end
    hold_line(1'b1, 2 * BITC);
  endtask

  function automatic logic [15:0] ctl(input bit ie, input int lsel, input bit one, input bit par);
    return 16'(ie) | (16'(lsel) << 11) | (16'(one) << 13) | (16'(par) << 14);
  endfunction

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  ch;
    int nb, hs;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd2, v); chk("R1 status after reset", v, 16'h0000);
    rd(2'd0, v); chk("R1 data after reset", v, 16'h0000);
    chk("R1 irq after reset", 16'(irq), 16'h0000);

    // Sweep of every format (R2, R3, R4, R6, R7)
    for (int c = 0; c < 16; c++) begin
      int lsel; bit one, par;
      lsel = c & 3; one = c[2]; par = c[3];
      nb = 8 - lsel;
      hs = one ? 2 : ((lsel == 3) ? 3 : 4);
      wr(2'd3, ctl(1'b0, lsel, one, par));
      for (int k = 0; k < 4; k++) begin
        ch = 8'((c * 37 + k * 91 + 5) & 255);
        send(ch, nb, par, hs, 1'b0, 1'b0);
        rd(2'd2, v); chk("R6 avail after char (R3 stop format)", v, 16'h0008);
        rd(2'd0, v); chk("R2 data right-justified (R4 parity ok)", v, 16'(ch & 8'((1 << nb) - 1)));
        rd(2'd2, v); chk("R7 read clears avail", v, 16'h0000);
      end
    end

    // R4 parity error discards
    wr(2'd3, ctl(1'b0, 0, 1'b1, 1'b1));
    send(8'h5A, 8, 1'b1, 2, 1'b1, 1'b0);
    rd(2'd2, v); chk("R4 bad parity not available", v, 16'h0000);
    send(8'h77, 8, 1'b1, 2, 1'b0, 1'b0);
    rd(2'd0, v); chk("R4 good frame after parity error", v, 16'h0077);

    // R3 framing error discards
    wr(2'd3, ctl(1'b0, 0, 1'b1, 1'b0));
    send(8'hC3, 8, 1'b0, 2, 1'b0, 1'b1);
    rd(2'd2, v); chk("R3 low stop bit not available", v, 16'h0000);
    send(8'h3C, 8, 1'b0, 2, 1'b0, 1'b0);
    rd(2'd0, v); chk("R3 good frame after framing error", v, 16'h003C);

    // R9 short glitch is not a start bit
    hold_line(1'b0, 6 * CLK_DIV);
    hold_line(1'b1, 3 * BITC);
    rd(2'd2, v); chk("R9 glitch ignored", v, 16'h0000);
    send(8'h81, 8, 1'b0, 2, 1'b0, 1'b0);
    rd(2'd0, v); chk("R9 midpoint sampling after glitch", v, 16'h0081);

    // R5 interrupt and monitor masking, R7 read under monitor
    wr(2'd3, ctl(1'b1, 0, 1'b1, 1'b0));
    send(8'hA5, 8, 1'b0, 2, 1'b0, 1'b0);
    chk("R5 irq raised", 16'(irq), 16'h0001);
    rd(2'd2, v); chk("R5 status enable and avail", v, 16'h0009);
    @(negedge clk); mon_active = 1'b1;
    @(negedge clk);
    chk("R5 irq masked by monitor", 16'(irq), 16'h0000);
    rd(2'd2, v); chk("R6 avail hidden by monitor", v, 16'h0001);
    rd(2'd0, v); chk("R7 data read under monitor", v, 16'h00A5);
    @(negedge clk); mon_active = 1'b0;
    @(negedge clk);
    rd(2'd2, v); chk("R7 flag kept through monitor read", v, 16'h0009);
    chk("R5 irq back after monitor", 16'(irq), 16'h0001);
    // R8 no-op read and ignored write
    rd(2'd1, v); chk("R8 no-op reads zero", v, 16'h0000);
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    rd(2'd2, v); chk("R8 no-op and data write change nothing", v, 16'h0009);
    rd(2'd0, v); chk("R7 data read", v, 16'h00A5);
    rd(2'd2, v); chk("R7 cleared", v, 16'h0001);
    chk("R5 irq dropped", 16'(irq), 16'h0000);

    // R6 character during monitor window
    @(negedge clk); mon_active = 1'b1;
    send(8'h4E, 8, 1'b0, 2, 1'b0, 1'b0);
    @(negedge clk); mon_active = 1'b0;
    @(negedge clk);
    rd(2'd2, v); chk("R6 not set during monitor", v, 16'h0001);
    chk("R6 no irq after monitor char", 16'(irq), 16'h0000);
    rd(2'd0, v); chk("R6 hold register updated", v, 16'h004E);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule